// File: doc/BRIEF.md
# Conditional Pending-Slot Issue Unit

This block sits after instruction decode in a processor built for data-triggered, non-blocking execution. A decoded operation carries an opcode tag, the index of a schedule condition chosen by the program, and the index of a trigger flag. If the selected schedule condition is true, the operation is parked in one of a small set of pending slots. If it is false, the operation is dropped. A parked operation waits without holding up fetch or decode. In every cycle it looks at its trigger flag. Once the flag is true it fires a strobe to its execution unit, and every other slot whose flag is also true fires in the same cycle.

Other units raise the trigger flags much as they would raise status flags, for example when an operand has arrived. The block keeps the flags in a register. Firing an operation clears its flag, unless a new set arrives in that same cycle. A separate wait-for-condition instruction is the only thing that suspends fetch: it holds fetch until a chosen flag is true. Parking operations never does this, and neither does starting a loop. When every slot is occupied, a newly scheduled operation stalls decode until a slot frees.

Top module: `pend_issue_unit`

## Requirements
- R1: When `dec_valid` is 1 and `cond_vec[dec_cond_sel]` is 1 and a slot is free, the operation is parked at that clock edge in the free slot with the lowest index (slot 0 first).
- R2: An operation whose selected schedule condition is 0 is dropped: it takes no slot and does not raise `dec_stall`.
- R3: A parked slot i drives `fire[i]` in every cycle in which the stored flag at its trigger index is 1, and drives its tag on `fire_tag[i*TAG_W +: TAG_W]`. While that flag is 0 the slot keeps waiting.
- R4: All slots whose flags are true fire in the same cycle, with no ordering between them.
- R5: In a firing cycle `flag_clr` shows the flags of the firing slots. At the next edge those flags fall to 0 and the slots become free.
- R6: A 1 on `flag_set[k]` makes flag k read 1 from the next cycle. If a set and a clear hit the same flag in the same cycle, the set wins.
- R7: A schedulable operation that arrives while all slots are occupied raises `dec_stall` in that cycle and is not taken. It is taken in the first cycle that starts with a free slot.
- R8: Parked or waiting operations never raise `fetch_stall`. Only a wait instruction does.
- R9: A wait instruction (`wait_valid`, `wait_sel`) raises `fetch_stall` from the next cycle. Once flag `wait_sel` reads 1 in some cycle, `fetch_stall` drops in the following cycle. The wait does not clear the flag.
- R10: While `rst_n` is 0, all slots are empty, all flags are 0, and `fire`, `flag_clr`, `dec_stall` and `fetch_stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | A decoded operation is present |
| dec_tag | input | TAG_W | Opcode tag of the operation |
| dec_cond_sel | input | CSEL_W | Index into `cond_vec` of its schedule condition |
| dec_trig_sel | input | FSEL_W | Index of the trigger flag it waits on |
| cond_vec | input | NCOND | Schedule condition bits |
| flag_set | input | NFLAG | Flag set pulses from other units |
| wait_valid | input | 1 | A wait-for-condition instruction is issued |
| wait_sel | input | FSEL_W | Flag the wait instruction waits on |
| fire | output | NSLOT | Per-slot fire strobe to the execution units |
| fire_tag | output | NSLOT*TAG_W | Per-slot tag, valid while its fire bit is set |
| flag_clr | output | NFLAG | Flags cleared by firing in this cycle |
| flags | output | NFLAG | Current trigger flag register |
| dec_stall | output | 1 | Decode must hold its operation |
| fetch_stall | output | 1 | Fetch is suspended by a wait instruction |

## Verification
The assertions check the following on every cycle: that allocation is one-hot, that a dropped operation never adds an occupied slot, that a firing slot is free at the next edge, that every set pulse lands and every cleared-but-not-set flag falls, that decode stalls only when all slots are full, and that a wait releases one cycle after its flag is seen. The bench scenarios show the rest. They show which slot each operation lands in, and that two slots on one flag fire together. They show a set winning over a clear in the same cycle, decode resuming exactly one cycle after a slot frees, and the wait window lasting from issue to flag plus one. Tags reaching the right strobe and the reset state are checked in directed tests.

// File: rtl/pis_pkg.sv
package pis_pkg;
  typedef enum logic {WAIT_IDLE = 1'b0, WAIT_HOLD = 1'b1} wait_st_e;
endpackage

// File: rtl/pis_flags.sv
module pis_flags #(
  parameter int NFLAG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flags_o
);
  // set dominates clear so a fresh trigger is never lost
  function automatic logic [NFLAG-1:0] next_flags(input logic [NFLAG-1:0] cur,
                                                  input logic [NFLAG-1:0] s,
                                                  input logic [NFLAG-1:0] c);
    return (cur & ~c) | s;
  endfunction

  logic [NFLAG-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= next_flags(flags_q, set_i, clr_i);
  end

  assign flags_o = flags_q;

  assert_set_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(set_i)) == $past(set_i)));
  assert_clear_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/pis_slot.sv
module pis_slot #(
  parameter int NFLAG  = 8,
  parameter int FSEL_W = 3,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [FSEL_W-1:0] load_sel_i,
  input  logic [TAG_W-1:0]  load_tag_i,
  input  logic [NFLAG-1:0]  flags_i,
  output logic              busy_o,
  output logic              fire_o,
  output logic [FSEL_W-1:0] sel_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic              busy_q;
  logic [FSEL_W-1:0] sel_q;
  logic [TAG_W-1:0]  tag_q;
  logic              trig_hit;

  assign trig_hit = flags_i[sel_q];
  assign fire_o   = busy_q & trig_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
      tag_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      sel_q  <= load_sel_i;
      tag_q  <= load_tag_i;
    end else if (fire_o) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign sel_o  = sel_q;
  assign tag_o  = tag_q;

  assert_load_only_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_q);
  assert_free_after_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !busy_q);
endmodule

// File: rtl/pis_wait.sv
module pis_wait
  import pis_pkg::*;
#(
  parameter int NFLAG  = 8,
  parameter int FSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wait_valid_i,
  input  logic [FSEL_W-1:0] wait_sel_i,
  input  logic [NFLAG-1:0]  flags_i,
  output logic              stall_o
);
  wait_st_e          st_q;
  logic [FSEL_W-1:0] sel_q;
  logic              release_ev;

  assign release_ev = (st_q == WAIT_HOLD) && flags_i[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WAIT_IDLE;
      sel_q <= '0;
    end else begin
      case (st_q)
        WAIT_IDLE: if (wait_valid_i) begin
          st_q  <= WAIT_HOLD;
          sel_q <= wait_sel_i;
        end
        default:   if (release_ev) st_q <= WAIT_IDLE;
      endcase
    end
  end

  assign stall_o = (st_q == WAIT_HOLD);

  assert_wait_enters_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && wait_valid_i) |=> stall_o);
  assert_wait_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> !stall_o);
endmodule

// File: rtl/pend_issue_unit.sv
module pend_issue_unit #(
  parameter int NSLOT = 4,
  parameter int NFLAG = 8,
  parameter int NCOND = 8,
  parameter int TAG_W = 4,
  localparam int FSEL_W = (NFLAG > 1) ? $clog2(NFLAG) : 1,
  localparam int CSEL_W = (NCOND > 1) ? $clog2(NCOND) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dec_valid,
  input  logic [TAG_W-1:0]       dec_tag,
  input  logic [CSEL_W-1:0]      dec_cond_sel,
  input  logic [FSEL_W-1:0]      dec_trig_sel,
  input  logic [NCOND-1:0]       cond_vec,
  input  logic [NFLAG-1:0]       flag_set,
  input  logic                   wait_valid,
  input  logic [FSEL_W-1:0]      wait_sel,
  output logic [NSLOT-1:0]       fire,
  output logic [NSLOT*TAG_W-1:0] fire_tag,
  output logic [NFLAG-1:0]       flag_clr,
  output logic [NFLAG-1:0]       flags,
  output logic                   dec_stall,
  output logic                   fetch_stall
);
  // lowest set bit of a vector, as a one-hot
  function automatic logic [NSLOT-1:0] lowest_one(input logic [NSLOT-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [NFLAG-1:0] flag_bit(input logic [FSEL_W-1:0] sel);
    return NFLAG'(1) << sel;
  endfunction

  logic [NSLOT-1:0]  slot_busy;
  logic [NSLOT-1:0]  slot_fire;
  logic [NSLOT-1:0]  alloc;
  logic [FSEL_W-1:0] slot_sel [NSLOT];
  logic [TAG_W-1:0]  slot_tag [NSLOT];
  logic [NFLAG-1:0]  flags_q;
  logic [NFLAG-1:0]  clr_vec;
  logic              cond_ok;
  logic              all_full;

  assign cond_ok   = dec_valid & cond_vec[dec_cond_sel];
  assign all_full  = &slot_busy;
  assign dec_stall = cond_ok & all_full;
  assign alloc     = cond_ok ? lowest_one(~slot_busy) : '0;

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_slot
      pis_slot #(.NFLAG(NFLAG), .FSEL_W(FSEL_W), .TAG_W(TAG_W)) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (alloc[gi]),
        .load_sel_i(dec_trig_sel),
        .load_tag_i(dec_tag),
        .flags_i   (flags_q),
        .busy_o    (slot_busy[gi]),
        .fire_o    (slot_fire[gi]),
        .sel_o     (slot_sel[gi]),
        .tag_o     (slot_tag[gi])
      );
      assign fire_tag[gi*TAG_W +: TAG_W] = slot_tag[gi];
    end
  endgenerate

  always_comb begin
    clr_vec = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_fire[i]) clr_vec = clr_vec | flag_bit(slot_sel[i]);
    end
  end

  pis_flags #(.NFLAG(NFLAG)) flags_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .clr_i  (clr_vec),
    .flags_o(flags_q)
  );

  pis_wait #(.NFLAG(NFLAG), .FSEL_W(FSEL_W)) wait_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wait_valid_i(wait_valid),
    .wait_sel_i  (wait_sel),
    .flags_i     (flags_q),
    .stall_o     (fetch_stall)
  );

  assign fire     = slot_fire;
  assign flag_clr = clr_vec;
  assign flags    = flags_q;

  assert_alloc_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc));
  assert_drop_no_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cond_vec[dec_cond_sel]) |=>
      ($countones(slot_busy) <= $past($countones(slot_busy))));
  assert_stall_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> (slot_busy == {NSLOT{1'b1}}));
  assert_fetch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wait_valid) && !$past(fetch_stall)) |-> !fetch_stall);
endmodule

// File: tb/pend_issue_unit_tb_top.sv
`timescale 1ns/1ps
module pend_issue_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [3:0]  dec_tag = '0;
  logic [2:0]  dec_cond_sel = '0;
  logic [2:0]  dec_trig_sel = '0;
  logic [7:0]  cond_vec = 8'h0D; // conditions 0,2,3 true; 1 false
  logic [7:0]  flag_set = '0;
  logic        wait_valid = 1'b0;
  logic [2:0]  wait_sel = '0;
  logic [3:0]  fire;
  logic [15:0] fire_tag;
  logic [7:0]  flag_clr;
  logic [7:0]  flags;
  logic        dec_stall;
  logic        fetch_stall;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pend_issue_unit dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_tag(dec_tag),
    .dec_cond_sel(dec_cond_sel), .dec_trig_sel(dec_trig_sel), .cond_vec(cond_vec),
    .flag_set(flag_set), .wait_valid(wait_valid), .wait_sel(wait_sel),
    .fire(fire), .fire_tag(fire_tag), .flag_clr(flag_clr), .flags(flags),
    .dec_stall(dec_stall), .fetch_stall(fetch_stall)
  );

  // {dv, csel, tsel, tag, fset, wv, wsel | fire, dstall, fstall, flags}
  localparam int NROW = 22;
  localparam logic [36:0] TBL [NROW] = '{
    {1'b0,3'd0,3'd0,4'h0,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h00},
    {1'b1,3'd0,3'd1,4'hA,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h00},
    {1'b1,3'd1,3'd2,4'hB,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h00},
    {1'b1,3'd2,3'd2,4'hC,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h00},
    {1'b1,3'd3,3'd3,4'hD,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h00},
    {1'b1,3'd0,3'd1,4'hE,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h00},
    {1'b1,3'd0,3'd4,4'hF,8'h02,1'b0,3'd0, 4'b0000,1'b1,1'b0,8'h00},
    {1'b1,3'd0,3'd4,4'hF,8'h00,1'b0,3'd0, 4'b1001,1'b1,1'b0,8'h02},
    {1'b1,3'd0,3'd4,4'hF,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h00},
    {1'b0,3'd0,3'd0,4'h0,8'h04,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h00},
    {1'b0,3'd0,3'd0,4'h0,8'h04,1'b0,3'd0, 4'b0010,1'b0,1'b0,8'h04},
    {1'b1,3'd0,3'd2,4'h9,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h04},
    {1'b0,3'd0,3'd0,4'h0,8'h18,1'b0,3'd0, 4'b0010,1'b0,1'b0,8'h04},
    {1'b0,3'd0,3'd0,4'h0,8'h00,1'b0,3'd0, 4'b0101,1'b0,1'b0,8'h18},
    {1'b0,3'd0,3'd0,4'h0,8'h00,1'b1,3'd5, 4'b0000,1'b0,1'b0,8'h00},
    {1'b1,3'd0,3'd6,4'h3,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b1,8'h00},
    {1'b0,3'd0,3'd0,4'h0,8'h20,1'b0,3'd0, 4'b0000,1'b0,1'b1,8'h00},
    {1'b0,3'd0,3'd0,4'h0,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b1,8'h20},
    {1'b0,3'd0,3'd0,4'h0,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h20},
    {1'b0,3'd0,3'd0,4'h0,8'h40,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h20},
    {1'b0,3'd0,3'd0,4'h0,8'h00,1'b0,3'd0, 4'b0001,1'b0,1'b0,8'h60},
    {1'b0,3'd0,3'd0,4'h0,8'h00,1'b0,3'd0, 4'b0000,1'b0,1'b0,8'h20}
  };

  function automatic string row_req(input int r);
    case (r)
      0:               return "R10";
      1, 3, 4, 5:      return "R1";
      2:               return "R2";
      6:               return "R7";
      7, 13:           return "R4";
      8:               return "R5";
      9, 11, 12:       return "R6";
      10, 20:          return "R3";
      15:              return "R8";
      default:         return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    dec_valid = 1'b0; dec_tag = '0; dec_cond_sel = '0; dec_trig_sel = '0;
    flag_set = '0; wait_valid = 1'b0; wait_sel = '0;
  endtask

  initial begin
    drive_idle();
    repeat (3) @(negedge clk);
    // r10_ reset state while held in reset
    check(fire == 4'h0 && flags == 8'h00 && !dec_stall && !fetch_stall && flag_clr == 8'h00,
          "R10", "reset outputs", {fire, flags, flag_clr, 6'b0, dec_stall, fetch_stall}, 32'h0);
    rst_n = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      dec_valid    = TBL[r][36];
      dec_cond_sel = TBL[r][35:33];
      dec_trig_sel = TBL[r][32:30];
      dec_tag      = TBL[r][29:26];
      flag_set     = TBL[r][25:18];
      wait_valid   = TBL[r][17];
      wait_sel     = TBL[r][16:14];
      #2;
      check(fire == TBL[r][13:10], row_req(r), $sformatf("row %0d fire", r), 32'(fire), 32'(TBL[r][13:10]));
      check(dec_stall == TBL[r][9], row_req(r), $sformatf("row %0d dec_stall", r), 32'(dec_stall), 32'(TBL[r][9]));
      check(fetch_stall == TBL[r][8], (r < 14) ? "R8" : row_req(r), $sformatf("row %0d fetch_stall", r),
            32'(fetch_stall), 32'(TBL[r][8]));
      check(flags == TBL[r][7:0], row_req(r), $sformatf("row %0d flags", r), 32'(flags), 32'(TBL[r][7:0]));
    end

    // R3: tag travels with the strobe; R5: flag_clr names the consumed flag
    @(negedge clk);
    drive_idle();
    dec_valid = 1'b1; dec_cond_sel = 3'd0; dec_trig_sel = 3'd7; dec_tag = 4'hB;
    @(negedge clk);
    drive_idle();
    flag_set = 8'h80;
    @(negedge clk);
    drive_idle();
    #2;
    check(fire == 4'b0001, "R3", "directed fire", 32'(fire), 32'h1);
    check(fire_tag[3:0] == 4'hB, "R3", "directed fire_tag", 32'(fire_tag[3:0]), 32'hB);
    check(flag_clr == 8'h80, "R5", "directed flag_clr", 32'(flag_clr), 32'h80);
    @(negedge clk);
    #2;
    check(flags == 8'h20 && fire == 4'h0, "R5", "flag consumed, slot freed",
          {20'b0, fire, flags}, 32'h20);

    // R10: reset mid-run wipes parked work and flags
    dec_valid = 1'b1; dec_trig_sel = 3'd5; dec_tag = 4'h6;
    @(negedge clk);
    drive_idle();
    wait_valid = 1'b1; wait_sel = 3'd1;
    @(negedge clk);
    drive_idle();
    rst_n = 1'b0;
    #2;
    check(fire == 4'h0 && flags == 8'h00 && !fetch_stall && flag_clr == 8'h00, "R10",
          "mid-run reset", {fire, flags, flag_clr, 7'b0, fetch_stall}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    flag_set = 8'h20;
    @(negedge clk);
    drive_idle();
    #2;
    check(fire == 4'h0, "R10", "no slot survives reset", 32'(fire), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule